// File: doc/BRIEF.md
# Two-Stage Locked Watchdog Timer

This block is a memory-mapped watchdog with two cascaded down-counters. Once enabled, the first counter runs down from its preload value. When it runs out it can raise an interrupt, and the second counter then starts from its own preload. When the second counter runs out, the block sets a sticky timeout flag and, if allowed, issues a one-cycle reset pulse. Software keeps the system alive by restarting the counters before the first stage runs out. The counters step on a tick that a prescaler derives from the input clock, and one of two divide ratios can be selected.

The preload registers and the reload register are protected. A write to any of them only takes effect after software writes a two-value key to the reload register. One protected write is then accepted and the block locks again. A sticky lock bit keeps the watchdog from being disabled until the next hardware reset. A free-running mode turns the block into a periodic interval timer: only the first stage counts, and no reset pulse is produced.

Top module: `wdt2_top`

## Requirements
- R1: After reset, both preload registers read PRELOAD_RST. The control register (offset 0x10) reads 0x03. The lock register (0x14), the status register (0x08) and the reload register (0x0C) read 0. irq_o and wdt_rst_o are low.
- R2: Writing 0x80 and then 0x86 to the reload register (offset 0x0C, low 16 bits compared) opens the block for exactly one protected write to preload 1 (0x00), preload 2 (0x04) or reload (0x0C). A second protected write without a new key is ignored.
- R3: A protected write that does not continue the key sequence sends the unlock logic back to idle. A write to a preload register while the block is locked leaves the register unchanged.
- R4: Counting starts when the block is enabled or restarted. After N1·P cycles, where N1 is the effective preload 1 and P is the tick period, status bit 0 is set and irq_o goes high. Both stay high until software writes 1 to status bit 0.
- R5: When control bits 1:0 equal 11, the first stage raises no interrupt, but the second stage still starts when the first stage runs out.
- R6: The second stage runs out (N1+N2)·P cycles after the start, where N2 is the effective preload 2. At that point the timeout flag (reload register bit 9) sets. In the same cycle, wdt_rst_o pulses high for one cycle if control bit 5 is 0. If control bit 5 is 1, no pulse is produced.
- R7: The timeout flag is cleared only by an unlocked write to the reload register with bit 9 set. Disabling the watchdog leaves the flag set.
- R8: An unlocked write to the reload register with bit 8 set restarts the prescaler and stage 1 from preload 1.
- R9: Lock register bit 0 is the lock and can only be set. While the lock is set, the enable bit (bit 1) cannot be cleared and the mode bit (bit 2) cannot change.
- R10: While the enable bit is 0, the counters and the prescaler are held, and neither irq_o nor wdt_rst_o can assert.
- R11: A preload value of zero counts as one tick.
- R12: Control bit 2 selects the tick period: 0 gives 2^SLOW_SHIFT clock cycles, and 1 gives 2^FAST_SHIFT clock cycles.
- R13: With lock register bit 2 set (free-running mode), stage 1 reloads itself every N1·P cycles and raises its interrupt each time. The second stage never runs, so wdt_rst_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, together with bus_sel |
| bus_addr | input | 5 | Byte address of the 32-bit register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | First-stage interrupt, level, held until cleared |
| wdt_rst_o | output | 1 | One-cycle reset pulse on second-stage expiry |

## Verification
The timing path is checked with many pairs of preload values. Each pair uses a different mix of tick rate, interrupt enable and reset enable. Because both preloads vary, the bench can tell the first-stage interval apart from the second-stage interval, and the two tick ratios apart from each other. Zero preloads check the one-tick floor. The protection logic is driven with right keys, wrong keys and keys that are out of order; a read-back of the preload registers shows which writes were accepted. A reload sent mid-count checks that the restart really moves the interrupt later. Separate runs in the disabled state, in free-running mode and with the lock set confirm that no output appears when it must not.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_HALF = 2'd1,
        UL_OPEN = 2'd2
    } unlock_e;

    typedef enum logic {
        ST_FIRST  = 1'b0,
        ST_SECOND = 1'b1
    } stage_e;

    localparam logic [15:0] KEY_FIRST  = 16'h0080;
    localparam logic [15:0] KEY_SECOND = 16'h0086;

    localparam logic [2:0] IDX_PRE1   = 3'd0;
    localparam logic [2:0] IDX_PRE2   = 3'd1;
    localparam logic [2:0] IDX_STAT   = 3'd2;
    localparam logic [2:0] IDX_RELOAD = 3'd3;
    localparam logic [2:0] IDX_CTRL   = 3'd4;
    localparam logic [2:0] IDX_LOCK   = 3'd5;

    localparam int RLD_RESTART_BIT = 8;
    localparam int RLD_FLAG_BIT    = 9;
endpackage

// File: rtl/wdt2_unlock.sv
module wdt2_unlock
    import wdt2_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_prot,
    input  logic        wr_reload,
    input  logic [15:0] wdata,
    output logic        open_o
);
    typedef struct packed {
        unlock_e st;
    } ul_t;

    ul_t d, q;

    always_comb begin
        d = q;
        if (wr_prot) begin
            unique case (q.st)
                UL_IDLE: d.st = (wr_reload && wdata == KEY_FIRST) ? UL_HALF : UL_IDLE;
                UL_HALF: d.st = (wr_reload && wdata == KEY_SECOND) ? UL_OPEN : UL_IDLE;
                default: d.st = UL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: UL_IDLE};
        else        q <= d;
    end

    assign open_o = (q.st == UL_OPEN);

    assert_single_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == UL_OPEN && wr_prot) |=> (q.st == UL_IDLE));

    assert_bad_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == UL_HALF && wr_prot && !(wr_reload && wdata == KEY_SECOND)) |=> (q.st == UL_IDLE));
endmodule

// File: rtl/wdt2_prescale.sv
module wdt2_prescale #(
    parameter int SLOW_SHIFT = 15,
    parameter int FAST_SHIFT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    input  logic fast,
    output logic tick_o
);
    localparam int PS_W = (SLOW_SHIFT > FAST_SHIFT) ? SLOW_SHIFT : FAST_SHIFT;
    localparam logic [PS_W-1:0] SLOW_LIM = PS_W'((64'd1 << SLOW_SHIFT) - 64'd1);
    localparam logic [PS_W-1:0] FAST_LIM = PS_W'((64'd1 << FAST_SHIFT) - 64'd1);

    typedef struct packed {
        logic [PS_W-1:0] cnt;
    } ps_t;

    ps_t d, q;
    logic [PS_W-1:0] lim;

    always_comb begin
        lim    = fast ? FAST_LIM : SLOW_LIM;
        tick_o = en && !restart && (q.cnt >= lim);
        d      = q;
        if (!en || restart || tick_o) d.cnt = '0;
        else                          d.cnt = q.cnt + PS_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/wdt2_stages.sv
module wdt2_stages
    import wdt2_pkg::*;
#(
    parameter int PRELOAD_W = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 restart,
    input  logic                 tick,
    input  logic                 free_run,
    input  logic [PRELOAD_W-1:0] pre1,
    input  logic [PRELOAD_W-1:0] pre2,
    output logic                 s1_fire_o,
    output logic                 s2_fire_o
);
    typedef struct packed {
        stage_e               stage;
        logic [PRELOAD_W-1:0] cnt;
    } stg_t;

    stg_t d, q;
    logic [PRELOAD_W-1:0] eff1, eff2;
    logic                 last, step;

    always_comb begin
        eff1      = (pre1 == '0) ? PRELOAD_W'(1) : pre1;
        eff2      = (pre2 == '0) ? PRELOAD_W'(1) : pre2;
        last      = (q.cnt <= PRELOAD_W'(1));
        step      = en && !restart && tick;
        s1_fire_o = step && last && (q.stage == ST_FIRST);
        s2_fire_o = step && last && (q.stage == ST_SECOND);
        d = q;
        if (!en || restart) begin
            d.stage = ST_FIRST;
            d.cnt   = eff1;
        end else if (step) begin
            if (!last) begin
                d.cnt = q.cnt - PRELOAD_W'(1);
            end else if (q.stage == ST_FIRST && !free_run) begin
                d.stage = ST_SECOND;
                d.cnt   = eff2;
            end else begin
                d.stage = ST_FIRST;
                d.cnt   = eff1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{stage: ST_FIRST, cnt: PRELOAD_W'(1)};
        else        q <= d;
    end
endmodule

// File: rtl/wdt2_top.sv
module wdt2_top
    import wdt2_pkg::*;
#(
    parameter int                   PRELOAD_W   = 20,
    parameter int                   SLOW_SHIFT  = 15,
    parameter int                   FAST_SHIFT  = 5,
    parameter logic [PRELOAD_W-1:0] PRELOAD_RST = '1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o,
    output logic        wdt_rst_o
);
    localparam int DATA_W = 32;

    typedef struct packed {
        logic [PRELOAD_W-1:0] pre1;
        logic [PRELOAD_W-1:0] pre2;
        logic                 rst_dis;
        logic                 tick_fast;
        logic [1:0]           irq_type;
        logic                 lock;
        logic                 en;
        logic                 free_run;
        logic                 irq_pend;
        logic                 flag;
        logic                 rst_pulse;
    } regs_t;

    regs_t d, q;
    logic [2:0] idx;
    logic       wr, wr_prot, wr_reload, ul_open, restart, tick, s1_fire, s2_fire;
    logic       unused_bits;

    assign idx         = bus_addr[4:2];
    assign wr          = bus_sel && bus_we;
    assign wr_reload   = wr && (idx == IDX_RELOAD);
    assign wr_prot     = wr && (idx == IDX_PRE1 || idx == IDX_PRE2 || idx == IDX_RELOAD);
    assign restart     = wr_reload && ul_open && bus_wdata[RLD_RESTART_BIT];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:PRELOAD_W]};

    wdt2_unlock u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_prot   (wr_prot),
        .wr_reload (wr_reload),
        .wdata     (bus_wdata[15:0]),
        .open_o    (ul_open)
    );

    wdt2_prescale #(.SLOW_SHIFT(SLOW_SHIFT), .FAST_SHIFT(FAST_SHIFT)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (q.en),
        .restart (restart),
        .fast    (q.tick_fast),
        .tick_o  (tick)
    );

    wdt2_stages #(.PRELOAD_W(PRELOAD_W)) u_stages (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (q.en),
        .restart   (restart),
        .tick      (tick),
        .free_run  (q.free_run),
        .pre1      (q.pre1),
        .pre2      (q.pre2),
        .s1_fire_o (s1_fire),
        .s2_fire_o (s2_fire)
    );

    always_comb begin
        d = q;
        if (wr && ul_open && idx == IDX_PRE1) d.pre1 = bus_wdata[PRELOAD_W-1:0];
        if (wr && ul_open && idx == IDX_PRE2) d.pre2 = bus_wdata[PRELOAD_W-1:0];
        if (wr && idx == IDX_CTRL) begin
            d.rst_dis   = bus_wdata[5];
            d.tick_fast = bus_wdata[2];
            d.irq_type  = bus_wdata[1:0];
        end
        if (wr && idx == IDX_LOCK) begin
            d.lock     = q.lock | bus_wdata[0];
            d.en       = q.lock ? (q.en | bus_wdata[1]) : bus_wdata[1];
            d.free_run = q.lock ? q.free_run : bus_wdata[2];
        end
        if (wr && idx == IDX_STAT && bus_wdata[0]) d.irq_pend = 1'b0;
        if (wr_reload && ul_open && bus_wdata[RLD_FLAG_BIT]) d.flag = 1'b0;
        if (s1_fire && q.irq_type != 2'b11) d.irq_pend = 1'b1;
        if (s2_fire) d.flag = 1'b1;
        d.rst_pulse = s2_fire && !q.rst_dis;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.pre1     <= PRELOAD_RST;
            q.pre2     <= PRELOAD_RST;
            q.irq_type <= 2'b11;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            IDX_PRE1:   bus_rdata[PRELOAD_W-1:0] = q.pre1;
            IDX_PRE2:   bus_rdata[PRELOAD_W-1:0] = q.pre2;
            IDX_STAT:   bus_rdata[0] = q.irq_pend;
            IDX_RELOAD: bus_rdata[RLD_FLAG_BIT] = q.flag;
            IDX_CTRL:   bus_rdata[5:0] = {q.rst_dis, 2'b00, q.tick_fast, q.irq_type};
            IDX_LOCK:   bus_rdata[2:0] = {q.free_run, q.en, q.lock};
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_o     = q.irq_pend;
    assign wdt_rst_o = q.rst_pulse;

    assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |=> !wdt_rst_o);

    assert_rst_with_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> q.flag);

    assert_lock_keeps_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lock && q.en) |=> (q.lock && q.en));

    assert_no_rst_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !q.en |=> !wdt_rst_o);

    assert_no_irq_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.en && !irq_o && !(wr && idx == IDX_LOCK)) |=> !irq_o);
endmodule

// File: tb/tb_wdt2_top.sv
module tb_wdt2_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          PW         = 20;
    localparam int          SLOW       = 3;
    localparam int          FAST       = 1;
    localparam logic [19:0] PRE_RST    = 20'h00ABC;

    localparam logic [4:0] A_PRE1 = 5'h00;
    localparam logic [4:0] A_PRE2 = 5'h04;
    localparam logic [4:0] A_STAT = 5'h08;
    localparam logic [4:0] A_RLD  = 5'h0C;
    localparam logic [4:0] A_CTRL = 5'h10;
    localparam logic [4:0] A_LOCK = 5'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, we = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, wrst;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt2_top #(.PRELOAD_W(PW), .SLOW_SHIFT(SLOW), .FAST_SHIFT(FAST), .PRELOAD_RST(PRE_RST)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .wdt_rst_o(wrst)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int n);
        return (n == 0) ? 1 : n;
    endfunction

    function automatic int period(input bit fast);
        return fast ? (1 << FAST) : (1 << SLOW);
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = v;
        @(negedge clk); sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk); addr = a; #1; v = rdata;
    endtask

    task automatic unlock();
        wr(A_RLD, 32'h80);
        wr(A_RLD, 32'h86);
    endtask

    task automatic measure(input int limit, output int irq_t, output int rst_t, output int rst_cnt);
        irq_t = -1; rst_t = -1; rst_cnt = 0;
        for (int k = 1; k <= limit; k++) begin
            @(negedge clk);
            if (irq && irq_t < 0) irq_t = k;
            if (wrst) begin
                if (rst_t < 0) rst_t = k;
                rst_cnt++;
            end
        end
    endtask

    task automatic setup(input int n1, input int n2, input bit fast, input bit irq_en, input bit rst_en);
        wr(A_LOCK, 32'h0);
        wr(A_CTRL, ((rst_en ? 0 : 1) << 5) | (int'(fast) << 2) | (irq_en ? 0 : 3));
        unlock(); wr(A_PRE1, n1);
        unlock(); wr(A_PRE2, n2);
        unlock(); wr(A_RLD, 32'h200);
        wr(A_STAT, 32'h1);
    endtask

    task automatic trial(input string tag, input int n1, input int n2, input bit fast,
                         input bit irq_en, input bit rst_en);
        int it, rt, rc, lim;
        logic [31:0] v;
        setup(n1, n2, fast, irq_en, rst_en);
        wr(A_LOCK, 32'h2);
        lim = (eff(n1) + eff(n2)) * period(fast) + 2;
        measure(lim, it, rt, rc);
        chk({tag, " R4/R5 irq time"}, it, irq_en ? eff(n1) * period(fast) : -1);
        chk({tag, " R6 rst time"}, rt, rst_en ? (eff(n1) + eff(n2)) * period(fast) : -1);
        chk({tag, " R6 rst width"}, rc, rst_en ? 1 : 0);
        rd(A_RLD, v);
        chk({tag, " R6 flag"}, int'(v), 32'h200);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int it, rt, rc;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_PRE1, v); chk("R1 pre1", int'(v), int'(PRE_RST));
        rd(A_PRE2, v); chk("R1 pre2", int'(v), int'(PRE_RST));
        rd(A_CTRL, v); chk("R1 ctrl", int'(v), 3);
        rd(A_LOCK, v); chk("R1 lock", int'(v), 0);
        rd(A_STAT, v); chk("R1 stat", int'(v), 0);
        rd(A_RLD, v);  chk("R1 reload", int'(v), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 rst", int'(wrst), 0);

        // R2 one write per unlock
        unlock(); wr(A_PRE1, 32'd5);
        rd(A_PRE1, v); chk("R2 unlocked write", int'(v), 5);
        wr(A_PRE2, 32'd7);
        rd(A_PRE2, v); chk("R2 second write ignored", int'(v), int'(PRE_RST));

        // R3 broken sequences
        wr(A_RLD, 32'h80); wr(A_RLD, 32'h11); wr(A_RLD, 32'h86); wr(A_PRE2, 32'd9);
        rd(A_PRE2, v); chk("R3 wrong key", int'(v), int'(PRE_RST));
        wr(A_RLD, 32'h80); wr(A_PRE1, 32'd9); wr(A_PRE1, 32'd11);
        rd(A_PRE1, v); chk("R3 half key", int'(v), 5);
        wr(A_RLD, 32'h86); wr(A_RLD, 32'h80); wr(A_PRE1, 32'd12);
        rd(A_PRE1, v); chk("R3 reversed key", int'(v), 5);

        // R4 R6 R12 slow tick
        trial("R12 slow", 3, 2, 1'b0, 1'b1, 1'b1);
        chk("R4 irq level held", int'(irq), 1);

        // R7 flag behaviour
        wr(A_LOCK, 32'h0);
        rd(A_RLD, v); chk("R7 kept after disable", int'(v), 32'h200);
        wr(A_RLD, 32'h200);
        rd(A_RLD, v); chk("R7 locked clear ignored", int'(v), 32'h200);
        unlock(); wr(A_RLD, 32'h200);
        rd(A_RLD, v); chk("R7 unlocked clear", int'(v), 0);
        wr(A_STAT, 32'h1);
        chk("R4 irq cleared", int'(irq), 0);

        // R11 zero preloads
        trial("R11 zero", 0, 0, 1'b1, 1'b1, 1'b1);
        // R5 irq disabled
        trial("R5 noirq", 2, 3, 1'b1, 1'b0, 1'b1);
        // R6 reset output disabled
        trial("R6 nopulse", 2, 2, 1'b1, 1'b1, 1'b0);

        // random mix
        for (int t = 0; t < 12; t++) begin
            trial("R12 random", $urandom_range(0, 5), $urandom_range(0, 5),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        // R8 mid-count restart
        setup(4, 4, 1'b1, 1'b1, 1'b1);
        wr(A_LOCK, 32'h2);
        unlock(); wr(A_RLD, 32'h100);
        chk("R8 no irq before restart", int'(irq), 0);
        measure(18, it, rt, rc);
        chk("R8 irq after restart", it, 8);
        chk("R8 rst after restart", rt, 16);

        // R10 disabled holds
        setup(1, 1, 1'b1, 1'b1, 1'b1);
        measure(30, it, rt, rc);
        chk("R10 no irq", it, -1);
        chk("R10 no rst", rc, 0);

        // R13 free-running
        setup(3, 1, 1'b1, 1'b1, 1'b1);
        wr(A_LOCK, 32'h6);
        measure(20, it, rt, rc);
        chk("R13 first irq", it, 6);
        chk("R13 no rst", rc, 0);
        wr(A_STAT, 32'h1);
        chk("R13 irq cleared", int'(irq), 0);
        repeat (3) @(negedge clk);
        chk("R13 irq repeats", int'(irq), 1);

        // R9 sticky lock
        wr(A_LOCK, 32'h0);
        wr(A_LOCK, 32'h3);
        rd(A_LOCK, v); chk("R9 locked", int'(v), 3);
        wr(A_LOCK, 32'h0);
        rd(A_LOCK, v); chk("R9 enable kept", int'(v), 3);
        wr(A_LOCK, 32'h4);
        rd(A_LOCK, v); chk("R9 mode frozen", int'(v), 3);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule